// File: doc/BRIEF.md
# EEPROM Word Command Engine

This block holds a small array of 16-bit words and gives a host single-word read and write access to it through a 32-bit command word. The host presents the command word together with a read strobe or a write strobe. The command carries a start bit, a word address and, for writes, a data value. At the next clock edge the engine performs the access and loads a 32-bit status word. The status word returns a completion flag, the address taken from the command and either the word read or the data written.

Two field layouts are supported, chosen by a parameter. The compact layout has an 8-bit address at bits [15:8] and the completion flag at bit 4. The wide layout has a 14-bit address at bits [15:2] and the completion flag at bit 1. In both layouts the start bit is bit 0 and the data occupies bits [31:16]. An address at or above the array depth performs no access. On reset the array is preloaded from an arithmetic series given by parameters.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: While reset is held and after its release, the status word reads zero until a command is strobed. Array word i holds INIT_BASE + i*INIT_STEP, truncated to 16 bits.
- R2: A command whose bit 0 (start) is clear performs no array access. The completion flag in the resulting status stays clear.
- R3: With WIDE_LAYOUT=0, the address is command bits [15:8] (8 bits) and the completion flag is status bit 4.
- R4: With WIDE_LAYOUT=1, the address is command bits [15:2] (14 bits) and the completion flag is status bit 1.
- R5: The data field is bits [31:16] in both the command word and the status word.
- R6: A read with start set and an address below WORDS loads the status with the completion flag set, the address echoed in its field and the stored word in the data field. Every other status bit is zero.
- R7: For an address at or above WORDS (64), no access occurs and the completion flag stays clear. A read returns zero data, and the address is still echoed.
- R8: A write with start set and an in-range address stores the data field into the array. Every write command loads the status with its own data echoed, whether or not the store happens, and sets the completion flag only when it stores.
- R9: The status updates on the clock edge that samples the strobe and is readable from the next cycle. A command strobed in the following cycle already sees a word stored by the previous write.
- R10: When both strobes are high in one cycle, the command is treated as a write and the read is ignored.
- R11: In a cycle with no strobe, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd_we | input | 1 | Strobe: the command word is a read command |
| wr_cmd_we | input | 1 | Strobe: the command word is a write command |
| cmd_wdata | input | 32 | Command word: start, address, data |
| status_rdata | output | 32 | Status word: completion flag, address, data |

## Verification
Every result is due exactly one edge after its strobe. The bench raises a strobe at a falling edge, lets one rising edge sample it, drops the strobe at the next falling edge and compares the status there. A stored word is checked by a read issued in the cycle right after the write. A held status is checked over several idle cycles. Both layouts are swept over every in-range address and over several out-of-range addresses. Expected words come from a shadow array that the bench fills with the preload series.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

    // Fields shared by both layouts
    localparam int START_BIT  = 0;
    localparam int DATA_LSB   = 16;
    localparam int DATA_W     = 16;
    localparam int ADDR_MAX_W = 14;

    // Compact layout
    localparam int NARROW_ADDR_LSB = 8;
    localparam int NARROW_ADDR_W   = 8;
    localparam int NARROW_DONE_BIT = 4;

    // Wide layout
    localparam int WIDE_ADDR_LSB = 2;
    localparam int WIDE_ADDR_W   = 14;
    localparam int WIDE_DONE_BIT = 1;

    typedef logic [DATA_W-1:0]     word_t;
    typedef logic [ADDR_MAX_W-1:0] addr_t;

    typedef struct packed {
        logic  start;
        addr_t addr;
        word_t data;
    } cmd_fields_t;

    typedef struct packed {
        logic [31:0] status;
    } eng_state_t;

endpackage

// File: rtl/eeprom_cmd_decode.sv
module eeprom_cmd_decode
    import eeprom_cmd_pkg::*;
#(
    parameter bit WIDE_LAYOUT = 1'b0,
    parameter int WORDS       = 64
) (
    input  logic [31:0] cmd,
    output cmd_fields_t fields,
    output logic        in_range
);

    localparam logic [ADDR_MAX_W:0] DEPTH = (ADDR_MAX_W+1)'(WORDS);

    addr_t addr_w;

    generate
        if (WIDE_LAYOUT) begin : g_wide
            logic unused_wide;
            assign unused_wide = cmd[1];
            assign addr_w = cmd[WIDE_ADDR_LSB +: WIDE_ADDR_W];
        end else begin : g_narrow
            logic unused_narrow;
            assign unused_narrow = ^cmd[7:1];
            assign addr_w = {{(ADDR_MAX_W-NARROW_ADDR_W){1'b0}},
                             cmd[NARROW_ADDR_LSB +: NARROW_ADDR_W]};
        end
    endgenerate

    always_comb begin
        fields.start = cmd[START_BIT];
        fields.addr  = addr_w;
        fields.data  = cmd[DATA_LSB +: DATA_W];
        // R7: depth check on the full address field
        in_range     = ({1'b0, addr_w} < DEPTH);
    end

endmodule

// File: rtl/eeprom_word_array.sv
module eeprom_word_array
    import eeprom_cmd_pkg::*;
#(
    parameter int    WORDS     = 64,
    parameter word_t INIT_BASE = 16'hA500,
    parameter word_t INIT_STEP = 16'h0103,
    localparam int   IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  word_t            wdata,
    input  logic [IDX_W-1:0] raddr,
    output word_t            rdata
);

    word_t mem_d [WORDS];
    word_t mem_q [WORDS];

    function automatic word_t preload(input int idx);
        return word_t'(INIT_BASE + word_t'(idx) * INIT_STEP);
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    // R1: preload series on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= preload(i);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/eeprom_status_fmt.sv
module eeprom_status_fmt
    import eeprom_cmd_pkg::*;
#(
    parameter bit WIDE_LAYOUT = 1'b0
) (
    input  logic        done,
    input  addr_t       addr,
    input  word_t       data,
    output logic [31:0] status
);

    generate
        if (WIDE_LAYOUT) begin : g_wide
            always_comb begin
                status = '0;
                status[WIDE_DONE_BIT] = done;
                status[WIDE_ADDR_LSB +: WIDE_ADDR_W] = addr;
                status[DATA_LSB +: DATA_W] = data;
            end
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_MAX_W-1:NARROW_ADDR_W];
            always_comb begin
                status = '0;
                status[NARROW_DONE_BIT] = done;
                status[NARROW_ADDR_LSB +: NARROW_ADDR_W] = addr[NARROW_ADDR_W-1:0];
                status[DATA_LSB +: DATA_W] = data;
            end
        end
    endgenerate

endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
    import eeprom_cmd_pkg::*;
#(
    parameter bit    WIDE_LAYOUT = 1'b0,
    parameter int    WORDS       = 64,
    parameter word_t INIT_BASE   = 16'hA500,
    parameter word_t INIT_STEP   = 16'h0103
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_cmd_we,
    input  logic        wr_cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] status_rdata
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    cmd_fields_t fields;
    logic        in_range;
    logic        hit;
    logic        store;
    word_t       rd_word;
    word_t       ret_data;
    logic [31:0] status_w;

    eng_state_t st_d;
    eng_state_t st_q;

    eeprom_cmd_decode #(
        .WIDE_LAYOUT (WIDE_LAYOUT),
        .WORDS       (WORDS)
    ) u_decode (
        .cmd      (cmd_wdata),
        .fields   (fields),
        .in_range (in_range)
    );

    // R2, R7: access only with start set and address in range
    assign hit   = fields.start && in_range;
    // R10: write strobe takes precedence
    assign store = wr_cmd_we && hit;

    eeprom_word_array #(
        .WORDS     (WORDS),
        .INIT_BASE (INIT_BASE),
        .INIT_STEP (INIT_STEP)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store),
        .waddr (fields.addr[IDX_W-1:0]),
        .wdata (fields.data),
        .raddr (fields.addr[IDX_W-1:0]),
        .rdata (rd_word)
    );

    // R8: a write echoes its own data; R6/R7: a read returns the word or zero
    always_comb begin
        if (wr_cmd_we) begin
            ret_data = fields.data;
        end else if (hit) begin
            ret_data = rd_word;
        end else begin
            ret_data = '0;
        end
    end

    eeprom_status_fmt #(
        .WIDE_LAYOUT (WIDE_LAYOUT)
    ) u_fmt (
        .done   (hit),
        .addr   (fields.addr),
        .data   (ret_data),
        .status (status_w)
    );

    // R9, R11: status loads on a strobe, holds otherwise
    always_comb begin
        st_d = st_q;
        if (rd_cmd_we || wr_cmd_we) begin
            st_d.status = status_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_rdata = st_q.status;

endmodule

// File: rtl/eeprom_cmd_engine_chk.sv
module eeprom_cmd_engine_chk #(
    parameter bit WIDE_LAYOUT = 1'b0,
    parameter int WORDS       = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_cmd_we,
    input logic        wr_cmd_we,
    input logic [31:0] cmd_wdata,
    input logic [31:0] status_rdata
);

    localparam int          ALSB  = WIDE_LAYOUT ? 2 : 8;
    localparam int          AW    = WIDE_LAYOUT ? 14 : 8;
    localparam int          DONE  = WIDE_LAYOUT ? 1 : 4;
    localparam logic [31:0] AMASK = (32'h1 << AW) - 32'h1;
    localparam logic [31:0] KEEP  = (AMASK << ALSB) | 32'hFFFF_0000 | (32'h1 << DONE);

    logic [31:0] c_addr;
    logic [31:0] s_addr;
    logic        strobe;
    logic        c_in;

    always_comb begin
        c_addr = (cmd_wdata >> ALSB) & AMASK;
        s_addr = (status_rdata >> ALSB) & AMASK;
        strobe = rd_cmd_we || wr_cmd_we;
        c_in   = c_addr < 32'(WORDS);
    end

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(status_rdata));

    // R2
    no_start_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cmd_wdata[0]) |=> !status_rdata[DONE]);

    // R7
    out_of_range_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !c_in) |=> !status_rdata[DONE]);

    // R6
    valid_access_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cmd_wdata[0] && c_in) |=> status_rdata[DONE]);

    // R3
    // R4
    addr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (s_addr == $past(c_addr)));

    // R8
    write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_we |=> (status_rdata[31:16] == $past(cmd_wdata[31:16])));

    // R7
    read_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_we && !wr_cmd_we && !(cmd_wdata[0] && c_in)) |=> (status_rdata[31:16] == 16'h0));

    // R6
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rdata & ~KEEP) == 32'h0);

endmodule

bind eeprom_cmd_engine eeprom_cmd_engine_chk #(
    .WIDE_LAYOUT (WIDE_LAYOUT),
    .WORDS       (WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_cmd_we    (rd_cmd_we),
    .wr_cmd_we    (wr_cmd_we),
    .cmd_wdata    (cmd_wdata),
    .status_rdata (status_rdata)
);

// File: tb/test_eeprom_cmd_engine.sv
module test_eeprom_cmd_engine;

    localparam int          N     = 64;
    localparam logic [15:0] IBASE = 16'hA500;
    localparam logic [15:0] ISTEP = 16'h0103;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        rd_n = 1'b0, wr_n = 1'b0, rd_w = 1'b0, wr_w = 1'b0;
    logic [31:0] st_n, st_w;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [15:0] shadow [2][N];

    always #10 clk = ~clk;

    eeprom_cmd_engine #(.WIDE_LAYOUT(1'b0), .WORDS(N), .INIT_BASE(IBASE), .INIT_STEP(ISTEP))
    i_eeprom_cmd_engine (
        .clk(clk), .rst_n(rst_n), .rd_cmd_we(rd_n), .wr_cmd_we(wr_n),
        .cmd_wdata(cmd_wdata), .status_rdata(st_n));

    eeprom_cmd_engine #(.WIDE_LAYOUT(1'b1), .WORDS(N), .INIT_BASE(IBASE), .INIT_STEP(ISTEP))
    i_eeprom_cmd_engine_wide (
        .clk(clk), .rst_n(rst_n), .rd_cmd_we(rd_w), .wr_cmd_we(wr_w),
        .cmd_wdata(cmd_wdata), .status_rdata(st_w));

    function automatic logic [31:0] mk_cmd(bit wide, bit start, int addr, logic [15:0] data);
        logic [31:0] w;
        w = {data, 16'h0};
        if (wide) w = w | ((32'(addr) & 32'h3FFF) << 2);
        else      w = w | ((32'(addr) & 32'hFF) << 8);
        w[0] = start;
        return w;
    endfunction

    function automatic logic [31:0] mk_stat(bit wide, bit done, int addr, logic [15:0] data);
        logic [31:0] w;
        w = mk_cmd(wide, 1'b0, addr, data);
        if (wide) w[1] = done;
        else      w[4] = done;
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(bit wide, bit rd, bit wr);
        if (wide) begin rd_w = rd; wr_w = wr; end
        else      begin rd_n = rd; wr_n = wr; end
    endtask

    // One command, checked one edge later
    task automatic op(string tag, bit wide, bit rd, bit wr, bit start, int addr, logic [15:0] data);
        bit          hit;
        logic [31:0] exp;
        hit = start && (addr < N);
        @(negedge clk);
        cmd_wdata = mk_cmd(wide, start, addr, data);
        strobe(wide, rd, wr);
        @(negedge clk);
        strobe(wide, 1'b0, 1'b0);
        if (wr) begin
            exp = mk_stat(wide, hit, addr, data);
            if (hit) shadow[wide][addr] = data;
        end else begin
            exp = mk_stat(wide, hit, addr, hit ? shadow[wide][addr] : 16'h0);
        end
        check(tag, wide ? st_w : st_n, exp);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            shadow[0][i] = 16'(IBASE + 16'(i) * ISTEP);
            shadow[1][i] = 16'(IBASE + 16'(i) * ISTEP);
        end
        repeat (3) @(negedge clk);
        check("R1 reset narrow", st_n, 32'h0);
        check("R1 reset wide", st_w, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle narrow", st_n, 32'h0);
        check("R1 idle wide", st_w, 32'h0);

        for (int wide = 0; wide < 2; wide++) begin
            string lay;
            lay = (wide == 1) ? "R4" : "R3";
            // R1 R6: preloaded contents
            for (int a = 0; a < N; a++) op({lay, " R1 R6 preload read"}, wide[0], 1'b1, 1'b0, 1'b1, a, 16'hFFFF);
            // R7: out-of-range reads
            op({lay, " R7 read 64"}, wide[0], 1'b1, 1'b0, 1'b1, 64, 16'h1111);
            op({lay, " R7 read far"}, wide[0], 1'b1, 1'b0, 1'b1, (wide == 1) ? 16383 : 255, 16'h2222);
            op({lay, " R7 read mid"}, wide[0], 1'b1, 1'b0, 1'b1, (wide == 1) ? 1000 : 130, 16'h3333);
            // R2: start clear
            op({lay, " R2 read no start"}, wide[0], 1'b1, 1'b0, 1'b0, 7, 16'h0);
            op({lay, " R2 write no start"}, wide[0], 1'b0, 1'b1, 1'b0, 5, 16'hDEAD);
            op({lay, " R2 read after ignored write"}, wide[0], 1'b1, 1'b0, 1'b1, 5, 16'h0);
            // R8: writes across the array
            for (int a = 0; a < N; a++)
                op({lay, " R8 write"}, wide[0], 1'b0, 1'b1, 1'b1, a, 16'(16'h5A00 ^ (a * 37 + wide * 11)));
            // R7 R8: out-of-range write echoes data, stores nothing
            op({lay, " R7 R8 write 64"}, wide[0], 1'b0, 1'b1, 1'b1, 64, 16'hBEEF);
            op({lay, " R7 read 0 after far write"}, wide[0], 1'b1, 1'b0, 1'b1, 0, 16'h0);
            for (int a = 0; a < N; a++) op({lay, " R8 read back"}, wide[0], 1'b1, 1'b0, 1'b1, a, 16'h0);
            // R10: both strobes -> write
            op({lay, " R10 both strobes"}, wide[0], 1'b1, 1'b1, 1'b1, 9, 16'h0F0F);
            op({lay, " R10 read back"}, wide[0], 1'b1, 1'b0, 1'b1, 9, 16'h0);
            // R5: data field placement
            check({lay, " R5 data field"}, {16'h0, ((wide == 1) ? st_w : st_n) >> 16}, 32'h0000_0F0F);
            // R9: write then read in the very next cycle
            @(negedge clk);
            cmd_wdata = mk_cmd(wide[0], 1'b1, 33, 16'h7E57);
            strobe(wide[0], 1'b0, 1'b1);
            @(negedge clk);
            check({lay, " R9 write status"}, (wide == 1) ? st_w : st_n, mk_stat(wide[0], 1'b1, 33, 16'h7E57));
            cmd_wdata = mk_cmd(wide[0], 1'b1, 33, 16'h0);
            strobe(wide[0], 1'b1, 1'b0);
            @(negedge clk);
            strobe(wide[0], 1'b0, 1'b0);
            shadow[wide][33] = 16'h7E57;
            check({lay, " R9 back-to-back read"}, (wide == 1) ? st_w : st_n, mk_stat(wide[0], 1'b1, 33, 16'h7E57));
            // R11: hold without strobe, command bus changing
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                cmd_wdata = 32'hFFFF_FFFF - 32'(k);
                check({lay, " R11 hold"}, (wide == 1) ? st_w : st_n, mk_stat(wide[0], 1'b1, 33, 16'h7E57));
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule